// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block runs the data movement for one DMA channel. A `start` pulse captures the source address, destination address and beat count. The engine then moves data over one shared memory port. It reads source-width beats into a small byte FIFO and writes destination-width beats out of it. It allows only one memory access in flight at a time.

The flow-control code chooses the pacing. Memory-to-memory transfers run without any request. Transfers with a peripheral side run only on credit. A peripheral request line or a software request grants that credit, and the credit counts source beats. The halt input blocks new requests. The block reports the following:

- `running` while the channel is enabled;
- `active` while the FIFO holds bytes;
- `done` at terminal count, with `irq` when the interrupt is enabled;
- `error` when a bus access ends with an error response.

Top module: `dma_chan_engine`

## Requirements
- R1: `cfg_count` (12 bits) counts beats at the source width. After `start`, the channel performs exactly that many source reads and then sets `done` and drops `running`. A count of zero finishes with no access. `irq` equals `done` AND `cfg_done_irq_en`. `start` clears `done`, `error` and the FIFO.
- R2: The width codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes, set separately per side. Bytes pass through the FIFO in little-endian order. Read data and write data are right-justified on `mem_rdata` and `mem_wdata`. `mem_size` carries the width code of the access. Writes are issued whenever the FIFO holds a whole destination beat.
- R3: When an increment enable is set, its address advances by its beat size after each beat. When the enable is clear, the address stays fixed.
- R4: Flow code 0 (memory to memory) starts reading without any request and pauses while `halt` is high.
- R5: Flow codes 1, 2 and 3 read only against credit. A burst request grants the beats given by burst code c: 1 for c = 0, otherwise 2^(c+1). The grant is capped at the beats still unread. A request is taken only when the credit is zero.
- R6: A `sw_single` pulse grants exactly one source beat.
- R7: While `halt` is high, request pulses grant no credit.
- R8: `active` is high exactly while the FIFO holds at least one byte. This includes a partial destination beat that waits for more credit.
- R9: An error response (`mem_err` with `mem_ack`) on any beat ends the channel. It sets `error`, clears `running`, leaves `done` low and issues no further access.
- R10: Flow codes 2 and 3 take peripheral requests from `periph_src_req`. Flow code 1 takes them from `periph_dst_req`. The other line is ignored.
- R11: `mem_req` stays high with a stable address until `mem_ack`. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse: capture addresses and count, enable channel |
| halt | input | 1 | Ignore new requests (and pause memory-to-memory reads) |
| cfg_src_addr | input | 32 | Source start address |
| cfg_dst_addr | input | 32 | Destination start address |
| cfg_count | input | 12 | Transfer length in source beats |
| cfg_src_width | input | 2 | Source beat width code |
| cfg_dst_width | input | 2 | Destination beat width code |
| cfg_src_burst | input | 3 | Burst size code for burst requests |
| cfg_src_inc | input | 1 | Source address increment enable |
| cfg_dst_inc | input | 1 | Destination address increment enable |
| cfg_flow | input | 2 | Flow-control code |
| cfg_done_irq_en | input | 1 | Completion interrupt enable |
| sw_single | input | 1 | Software single-beat request pulse |
| sw_burst | input | 1 | Software burst request pulse |
| periph_src_req | input | 1 | Source-side peripheral burst request pulse |
| periph_dst_req | input | 1 | Destination-side peripheral burst request pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access byte address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, right-justified |
| running | output | 1 | Channel enabled |
| active | output | 1 | FIFO holds data |
| done | output | 1 | Terminal count reached |
| error | output | 1 | Stopped by a bus error |
| irq | output | 1 | Completion interrupt |

## Verification
The bench drives a halt and a peripheral request in the same clock cycle. Halt must win: no read may follow, and `running` stays high until a later request arrives with halt low.

A second overlap occurs at the end of a paced transfer. There, the credit is capped in the same grant that leaves a short final burst. The bench counts the reads after each request to confirm the shortened burst. The scoreboard then confirms that every byte is written in little-endian order.

// File: rtl/dma_chan_pkg.sv
// Package: shared encodings and decode helpers for the DMA channel engine.
// Assumes width code 3 is never programmed; it is treated as 4 bytes.
package dma_chan_pkg;

    typedef enum logic [1:0] {
        FLOW_M2M = 2'd0,
        FLOW_M2P = 2'd1,
        FLOW_P2M = 2'd2,
        FLOW_P2P = 2'd3
    } flow_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } xfer_state_e;

    // Beats granted by a burst code: 1, then 4 doubling to 256.
    function automatic logic [8:0] burst_beats(input logic [2:0] code);
        logic [3:0] sh;
        sh = {1'b0, code} + 4'd1;
        return (code == 3'd0) ? 9'd1 : (9'd1 << sh);
    endfunction

    // Bytes in one beat of a width code.
    function automatic logic [2:0] width_bytes(input logic [1:0] w);
        case (w)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_byte_fifo.sv
// Byte FIFO with multi-byte push and pop, little-endian lane order.
// Assumes DEPTH is a power of two and callers never overfill or overdrain it.
module dma_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push,
    input  logic [2:0]                 push_n,
    input  logic [8*LANES-1:0]         push_data,
    input  logic                       pop,
    input  logic [2:0]                 pop_n,
    output logic [8*LANES-1:0]         pop_data,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    store [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // Byte storage write: lane l lands at wr_ptr+l.
    always_ff @(posedge clk) begin
        if (push) begin
            for (int l = 0; l < LANES; l++) begin
                if (l < int'(push_n)) store[wr_ptr + PW'(l)] <= push_data[8*l +: 8];
            end
        end
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PW'(push_n);
            if (pop)  rd_ptr <= rd_ptr + PW'(pop_n);
            level <= level + (push ? CW'(push_n) : CW'(0)) - (pop ? CW'(pop_n) : CW'(0));
        end
    end

    // Output lanes: oldest byte on lane 0, unused lanes zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign pop_data[8*g +: 8] = (g < int'(pop_n)) ? store[rd_ptr + PW'(g)] : 8'h00;
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |-> (int'(level) + int'(push_n) <= DEPTH));
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear) |-> (int'(pop_n) <= int'(level)));

endmodule

// File: rtl/dma_pacer.sv
// Request pacer: turns request pulses into a credit of source beats.
// Assumes CNT_W >= 9 so that a 256-beat grant fits.
module dma_pacer
    import dma_chan_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             halt,
    input  logic             paced,
    input  logic             req_burst,
    input  logic             req_single,
    input  logic [2:0]       burst_code,
    input  logic [CNT_W-1:0] beats_left,
    input  logic             consume,
    output logic             permit
);
    logic [CNT_W-1:0] credit;
    logic [CNT_W-1:0] grant;
    logic [CNT_W-1:0] capped;

    // Beats requested now, capped to what is still unread.
    always_comb begin
        grant  = req_burst ? CNT_W'(burst_beats(burst_code)) : CNT_W'(1);
        capped = (beats_left < grant) ? beats_left : grant;
    end

    // Credit counter: load on an accepted request, drain on each read beat.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            credit <= '0;
        end else if (paced && consume && credit != '0) begin
            credit <= credit - CNT_W'(1);
        end else if (paced && credit == '0 && !halt && (req_burst || req_single)) begin
            credit <= capped;
        end
    end

    assign permit = paced ? (credit != '0) : !halt;

    assert_halt_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && credit == '0) |=> (credit == '0));

endmodule

// File: rtl/dma_chan_engine.sv
// One DMA channel: sequences reads into a byte FIFO and writes out of it over a
// single-outstanding memory port, paced by the flow-control mode.
// Assumes cfg_* stay stable while running, and count*src bytes is a multiple
// of the destination beat size.
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 12,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              halt,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [1:0]        cfg_src_width,
    input  logic [1:0]        cfg_dst_width,
    input  logic [2:0]        cfg_src_burst,
    input  logic              cfg_src_inc,
    input  logic              cfg_dst_inc,
    input  logic [1:0]        cfg_flow,
    input  logic              cfg_done_irq_en,
    input  logic              sw_single,
    input  logic              sw_burst,
    input  logic              periph_src_req,
    input  logic              periph_dst_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic              running,
    output logic              active,
    output logic              done,
    output logic              error,
    output logic              irq
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    xfer_state_e      state;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [CNT_W-1:0] reads_left;
    logic [LVL_W-1:0] fifo_level;
    logic [2:0]       src_bytes, dst_bytes;
    logic             paced, line_req, permit;
    logic             want_wr, want_rd, finish;
    logic             rd_ok, wr_ok, bus_fail, fifo_clear;

    // Mode decode and next-action choice (writes take priority).
    always_comb begin
        src_bytes = width_bytes(cfg_src_width);
        dst_bytes = width_bytes(cfg_dst_width);
        paced     = (cfg_flow != FLOW_M2M);
        line_req  = (cfg_flow == FLOW_M2P) ? periph_dst_req : (paced && periph_src_req);
        want_wr   = running && (int'(fifo_level) >= int'(dst_bytes));
        want_rd   = running && (reads_left != '0) && permit &&
                    (int'(fifo_level) + int'(src_bytes) <= FIFO_DEPTH);
        finish    = running && (state == ST_IDLE) && (reads_left == '0) &&
                    (int'(fifo_level) < int'(dst_bytes));
        rd_ok     = (state == ST_RD) && mem_ack && !mem_err;
        wr_ok     = (state == ST_WR) && mem_ack && !mem_err;
        bus_fail  = (state != ST_IDLE) && mem_ack && mem_err;
        fifo_clear = start || finish || bus_fail;
    end

    // Channel sequencer: enable, address stepping, beat count and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            running    <= 1'b0;
            done       <= 1'b0;
            error      <= 1'b0;
            src_addr   <= '0;
            dst_addr   <= '0;
            reads_left <= '0;
        end else if (start) begin
            state      <= ST_IDLE;
            running    <= 1'b1;
            done       <= 1'b0;
            error      <= 1'b0;
            src_addr   <= cfg_src_addr;
            dst_addr   <= cfg_dst_addr;
            reads_left <= cfg_count;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (finish) begin
                        running <= 1'b0;
                        done    <= 1'b1;
                    end else if (want_wr) begin
                        state <= ST_WR;
                    end else if (want_rd) begin
                        state <= ST_RD;
                    end
                end
                default: begin
                    if (mem_ack) state <= ST_IDLE;
                    if (bus_fail) begin
                        running <= 1'b0;
                        error   <= 1'b1;
                    end
                    if (rd_ok) begin
                        reads_left <= reads_left - CNT_W'(1);
                        src_addr   <= src_addr + (cfg_src_inc ? ADDR_W'(src_bytes) : '0);
                    end
                    if (wr_ok) begin
                        dst_addr <= dst_addr + (cfg_dst_inc ? ADDR_W'(dst_bytes) : '0);
                    end
                end
            endcase
        end
    end

    dma_pacer #(.CNT_W(CNT_W)) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .halt       (halt),
        .paced      (paced),
        .req_burst  (sw_burst || line_req),
        .req_single (sw_single),
        .burst_code (cfg_src_burst),
        .beats_left (reads_left),
        .consume    (rd_ok),
        .permit     (permit)
    );

    dma_byte_fifo #(.DEPTH(FIFO_DEPTH), .LANES(4)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (fifo_clear),
        .push      (rd_ok),
        .push_n    (src_bytes),
        .push_data (mem_rdata),
        .pop       (wr_ok),
        .pop_n     (dst_bytes),
        .pop_data  (mem_wdata),
        .level     (fifo_level)
    );

    // Memory port and status outputs.
    always_comb begin
        mem_req  = (state != ST_IDLE);
        mem_we   = (state == ST_WR);
        mem_addr = mem_we ? dst_addr : src_addr;
        mem_size = mem_we ? cfg_dst_width : cfg_src_width;
        active   = (fifo_level != '0);
        irq      = done && cfg_done_irq_en;
    end

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !start) |=> (mem_req && $stable(mem_addr)));
    assert_err_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> (!running && !done));
    assert_done_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (reads_left == '0 && !mem_req));
    assert_no_wr_partial_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (int'(fifo_level) >= int'(dst_bytes)));

endmodule

// File: tb/dma_chan_engine_test.sv
// Scoreboard bench: tasks push expected writes, a negedge monitor compares them.
module dma_chan_engine_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        start = 0, halt = 0;
    logic [31:0] cfg_src_addr = 0, cfg_dst_addr = 0;
    logic [11:0] cfg_count = 0;
    logic [1:0]  cfg_src_width = 0, cfg_dst_width = 0, cfg_flow = 0;
    logic [2:0]  cfg_src_burst = 0;
    logic        cfg_src_inc = 0, cfg_dst_inc = 0, cfg_done_irq_en = 0;
    logic        sw_single = 0, sw_burst = 0, periph_src_req = 0, periph_dst_req = 0;
    logic        mem_req, mem_we, mem_ack = 0, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        running, active, done, error, irq;

    dma_chan_engine uut (.*);

    logic [7:0]  mem [1024];
    logic        err_en = 0;
    logic [31:0] err_addr = 0;
    int checks = 0, errors = 0, rd_seen = 0, wr_seen = 0, cyc = 0;
    logic [65:0] exp_q [$];
    string       tag_q [$];

    function automatic int nbytes(input logic [1:0] w);
        return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] rd_le(input logic [31:0] a, input int n);
        logic [31:0] v = '0;
        for (int b = 0; b < n; b++) v[8*b +: 8] = mem[(a[9:0] + 10'(b))];
        return v;
    endfunction

    // Memory model: ack one cycle after request, optional error address.
    always @(posedge clk) mem_ack <= rst_n && mem_req && !mem_ack;
    always_comb mem_rdata = rd_le(mem_addr, nbytes(mem_size));
    assign mem_err = mem_ack && err_en && (mem_addr == err_addr);

    task automatic chk(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s, input string tag);
        exp_q.push_back({s, a, d});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each completing write against the scoreboard.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && mem_req && mem_ack && !mem_err) begin
            if (!mem_we) rd_seen++;
            else begin
                wr_seen++;
                if (exp_q.size() == 0) chk(0, "R2 unexpected write", {mem_size, mem_addr, mem_wdata}, '0);
                else begin
                    logic [65:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({mem_size, mem_addr, mem_wdata} == e, t, {mem_size, mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        wait (cyc > 100000);
        chk(0, "watchdog", 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input int n,
                         input logic [1:0] sw, input logic [1:0] dw, input logic [2:0] bc,
                         input bit si, input bit di, input logic [1:0] fl, input bit ie);
        @(negedge clk);
        cfg_src_addr = s; cfg_dst_addr = d; cfg_count = 12'(n);
        cfg_src_width = sw; cfg_dst_width = dw; cfg_src_burst = bc;
        cfg_src_inc = si; cfg_dst_inc = di; cfg_flow = fl; cfg_done_irq_en = ie;
        rd_seen = 0; wr_seen = 0;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_stop(input string tag);
        int k = 0;
        while (running && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk(!running, tag, running, 0);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: sw_single = 1;
            1: sw_burst = 1;
            2: periph_src_req = 1;
            default: periph_dst_req = 1;
        endcase
        @(negedge clk);
        sw_single = 0; sw_burst = 0; periph_src_req = 0; periph_dst_req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
        idle(3);
        chk(!mem_req && !running && !active && !done && !error && !irq, "R1 reset state",
            {mem_req, running, active, done, error, irq}, 0);
        rst_n = 1;
        idle(2);

        // R1, R4: memory to memory, 32 to 32, incrementing, irq enabled.
        for (int k = 0; k < 4; k++) expect_wr(32'h100 + 4*k, rd_le(32'h000 + 4*k, 4), 2, "R1 m2m word");
        setup(32'h000, 32'h100, 4, 2, 2, 0, 1, 1, 0, 1);
        wait_stop("R4 m2m runs unpaced");
        chk(done && irq && !error && rd_seen == 4, "R1 done irq count", {done, irq, error, 32'(rd_seen)}, {3'b110, 32'd4});
        chk(exp_q.size() == 0, "R1 all writes seen", exp_q.size(), 0);

        // R2: pack bytes into words, irq disabled.
        for (int k = 0; k < 2; k++) expect_wr(32'h200 + 4*k, rd_le(32'h010 + 4*k, 4), 2, "R2 pack 8 to 32");
        setup(32'h010, 32'h200, 8, 0, 2, 0, 1, 1, 0, 0);
        wait_stop("R2 pack finish");
        chk(done && !irq && rd_seen == 8 && wr_seen == 2, "R1 irq masked counts", {done, irq, 32'(rd_seen), 32'(wr_seen)}, {2'b10, 32'd8, 32'd2});

        // R2: unpack words into halfwords.
        for (int k = 0; k < 4; k++) expect_wr(32'h280 + 2*k, rd_le(32'h020 + 2*k, 2), 1, "R2 unpack 32 to 16");
        setup(32'h020, 32'h280, 2, 2, 1, 0, 1, 1, 0, 0);
        wait_stop("R2 unpack finish");
        chk(exp_q.size() == 0, "R2 unpack complete", exp_q.size(), 0);

        // R3: fixed destination, then fixed source.
        for (int k = 0; k < 3; k++) expect_wr(32'h300, rd_le(32'h030 + 4*k, 4), 2, "R3 fixed dst");
        setup(32'h030, 32'h300, 3, 2, 2, 0, 1, 0, 0, 0);
        wait_stop("R3 fixed dst finish");
        expect_wr(32'h340, {2{mem[10'h033]}}, 1, "R3 fixed src");
        setup(32'h033, 32'h340, 2, 0, 1, 0, 0, 1, 0, 0);
        wait_stop("R3 fixed src finish");

        // R1: zero count finishes with no access.
        setup(32'h000, 32'h3C0, 0, 2, 2, 0, 1, 1, 0, 0);
        idle(5);
        chk(done && !running && rd_seen == 0, "R1 zero count", {done, running, 32'(rd_seen)}, {2'b10, 32'd0});

        // R5, R10: peripheral to memory, burst code 1 (4 beats), count 6.
        for (int k = 0; k < 6; k++) expect_wr(32'h400 + 4*k, rd_le(32'h040 + 4*k, 4), 2, "R5 paced data");
        setup(32'h040, 32'h400, 6, 2, 2, 1, 1, 1, 2, 0);
        idle(10);
        chk(rd_seen == 0 && running, "R5 waits for request", rd_seen, 0);
        pulse(3);
        idle(30);
        chk(rd_seen == 0, "R10 dst line ignored for flow 2", rd_seen, 0);
        pulse(2);
        idle(40);
        chk(rd_seen == 4 && running, "R5 burst of 4", rd_seen, 4);
        pulse(2);
        wait_stop("R5 short last burst");
        chk(rd_seen == 6 && done, "R5 capped last burst", rd_seen, 6);

        // R5: burst code 3 grants 16 beats.
        for (int k = 0; k < 20; k++) expect_wr(32'h500 + k, {24'h0, mem[10'h0A0 + 10'(k)]}, 0, "R5 code 3 data");
        setup(32'h0A0, 32'h500, 20, 0, 0, 3, 1, 1, 2, 0);
        pulse(1);
        idle(100);
        chk(rd_seen == 16, "R5 burst code 3 is 16", rd_seen, 16);
        pulse(1);
        wait_stop("R5 code 3 finish");

        // R6, R10: memory to peripheral, single request, then dst line.
        for (int k = 0; k < 2; k++) expect_wr(32'h600, rd_le(32'h0C0 + 4*k, 4), 2, "R6 m2p data");
        setup(32'h0C0, 32'h600, 2, 2, 2, 2, 1, 0, 1, 0);
        pulse(2);
        idle(20);
        chk(rd_seen == 0, "R10 src line ignored for flow 1", rd_seen, 0);
        pulse(0);
        idle(20);
        chk(rd_seen == 1 && running, "R6 single is one beat", rd_seen, 1);
        pulse(3);
        wait_stop("R10 dst line paces flow 1");
        chk(rd_seen == 2, "R10 dst request grant", rd_seen, 2);

        // R7: halt and request in the same cycle.
        for (int k = 0; k < 2; k++) expect_wr(32'h680 + 4*k, rd_le(32'h0D0 + 4*k, 4), 2, "R7 halt data");
        setup(32'h0D0, 32'h680, 2, 2, 2, 1, 1, 1, 2, 0);
        @(negedge clk);
        halt = 1; periph_src_req = 1;
        @(negedge clk);
        periph_src_req = 0;
        idle(20);
        chk(rd_seen == 0 && running, "R7 halted request ignored", rd_seen, 0);
        halt = 0;
        pulse(2);
        wait_stop("R7 resume after halt");

        // R8: partial word held while credit runs out.
        expect_wr(32'h700, rd_le(32'h0E0, 4), 2, "R8 packed word");
        setup(32'h0E0, 32'h700, 4, 0, 2, 1, 1, 1, 2, 0);
        pulse(0);
        idle(20);
        chk(active && rd_seen == 1 && wr_seen == 0, "R8 active with partial data", {active, 32'(rd_seen)}, {1'b1, 32'd1});
        pulse(1);
        wait_stop("R8 finish");
        chk(!active && done, "R8 inactive when empty", active, 0);

        // R9: error on the second read.
        expect_wr(32'h780, rd_le(32'h080, 4), 2, "R9 first beat");
        err_en = 1; err_addr = 32'h084;
        setup(32'h080, 32'h780, 4, 2, 2, 0, 1, 1, 0, 1);
        wait_stop("R9 stops on error");
        idle(5);
        chk(error && !done && !irq && !active && !mem_req, "R9 error state",
            {error, done, irq, active, mem_req}, 5'b10000);
        chk(exp_q.size() == 0 && rd_seen == 1, "R9 no further access", rd_seen, 1);
        err_en = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule